// File: doc/BRIEF.md
# Endpoint-Zero Host Transaction Control Register

This block holds the control and status word for the default control pipe of a USB host controller. It also runs the small sequencer behind that word. Software sets a request bit to launch a transaction. The block then picks the token type from a second bit and keeps track of the DATA0/DATA1 toggle. It asks a packet engine to run the transaction, one attempt at a time.

The packet engine reports each attempt as one of four results: acknowledged, NAK, STALL, or no response. On a NAK the block launches the attempt again. After three silent attempts in a row it gives up and raises an error flag. A STALL also ends the request. Independently of the sequencer, the engine can signal that a data packet has landed in the receive buffer. Every notable event produces a single-cycle interrupt pulse.

Top module: `ep0_host_csr`

## Requirements
- R1: After reset, all five status bits read 0, the toggle output is 0 (DATA0), and neither the start output nor the interrupt is asserted. The read word is laid out as bit 4 error, bit 3 setup, bit 2 stalled, bit 1 request, bit 0 receive-ready.
- R2: Each launched attempt asserts the start output for one cycle. The token output is 1 (SETUP) when the setup bit is 1 while the request is pending, and 0 (OUT) when the setup bit is 0.
- R3: A register write with bit 3 set forces the toggle to DATA0, so the next attempt goes out with the data-phase output at 0.
- R4: An acknowledged attempt (result code 0) clears the request bit, flips the toggle, and pulses the interrupt.
- R5: A NAK (result code 1) relaunches the same transaction and leaves the toggle unchanged. It also resets the count of silent attempts, so a NAK between silent attempts prevents the error.
- R6: Three consecutive attempts that end in no response (result code 3) set the error bit, clear the request bit and pulse the interrupt. Two silent attempts followed by an acknowledge leave the error bit at 0.
- R7: A STALL (result code 2) sets the stalled bit, clears the request bit and pulses the interrupt, and leaves the toggle unchanged.
- R8: The error and stalled bits are cleared only by a write of 0 to their position. Writing 1 to them leaves them as they were.
- R9: A receive-packet pulse sets the receive-ready bit and pulses the interrupt. A write of 0 to bit 0 clears it.
- R10: Each interrupt event produces a pulse exactly one cycle wide.
- R11: Once a request has ended in error or stall, no further attempt starts until software writes the request bit again.
- R12: A request write while a request is already pending starts nothing extra. A result reported while no attempt is outstanding changes no bit, no toggle and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 5 | Register write value |
| csr_rd_data | output | 5 | Current register value |
| res_valid | input | 1 | Packet engine result strobe |
| res_kind | input | 2 | Result code: 0 ack, 1 NAK, 2 STALL, 3 no response |
| rx_pkt | input | 1 | A data packet was stored in the receive buffer |
| xact_start | output | 1 | Start one attempt |
| xact_setup | output | 1 | Token for this attempt: 1 SETUP, 0 OUT |
| xact_data1 | output | 1 | Data PID toggle: 1 DATA1, 0 DATA0 |
| ep0_irq | output | 1 | Endpoint-zero interrupt pulse |

## Verification
The hardest condition to reach is the retry counter sitting at two silent attempts when a different result arrives. Only at that point does it matter whether a NAK or an acknowledge resets the count. The bench gets there with a scripted packet engine stub that replays a queue of result codes, one per observed start. It builds sequences such as silent, silent, NAK, silent, silent, acknowledge, and compares every start's token and toggle against a scoreboard queue. A stray result injected while the sequencer is idle covers the ignore case.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

    localparam int CSR_W = 5;

    typedef enum logic [1:0] {
        RES_ACK    = 2'd0,
        RES_NAK    = 2'd1,
        RES_STALL  = 2'd2,
        RES_NORESP = 2'd3
    } res_kind_e;

    // Field order mirrors the read word, bit 4 down to bit 0.
    typedef struct packed {
        logic error;
        logic setup;
        logic stalled;
        logic txrdy;
        logic rxrdy;
    } csr_t;

    typedef struct packed {
        logic ack;
        logic stall;
        logic abort;
    } seq_evt_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    // A result that comes back from the device resets the silent-attempt count.
    function automatic logic is_handshake(input res_kind_e k);
        return (k == RES_ACK) || (k == RES_NAK) || (k == RES_STALL);
    endfunction

endpackage

// File: rtl/ep0_xact_seq.sv
module ep0_xact_seq
    import ep0_pkg::*;
#(
    parameter int RETRY_LIMIT = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  logic     res_valid,
    input  logic [1:0] res_kind,
    output logic     start,
    output seq_evt_t evt
);
    localparam int CNT_W = $clog2(RETRY_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_TRY = CNT_W'(RETRY_LIMIT - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] tries_q;
    res_kind_e        kind;
    logic             resp;
    logic             last;

    assign kind  = res_kind_e'(res_kind);
    assign resp  = (state_q == SQ_WAIT) && res_valid;
    assign last  = (tries_q == LAST_TRY);
    assign start = (state_q == SQ_ISSUE);

    always_comb begin
        evt       = '0;
        evt.ack   = resp && (kind == RES_ACK);
        evt.stall = resp && (kind == RES_STALL);
        evt.abort = resp && (kind == RES_NORESP) && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            tries_q <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (launch) begin
                        state_q <= SQ_ISSUE;
                        tries_q <= '0;
                    end
                end
                SQ_ISSUE: state_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (resp) begin
                        if (is_handshake(kind)) begin
                            tries_q <= '0;
                            state_q <= (kind == RES_NAK) ? SQ_ISSUE : SQ_IDLE;
                        end else if (last) begin
                            tries_q <= '0;
                            state_q <= SQ_IDLE;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            state_q <= SQ_ISSUE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ep0_csr_bank.sv
module ep0_csr_bank
    import ep0_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  seq_evt_t         evt,
    input  logic             rx_pkt,
    output csr_t             csr,
    output logic             toggle,
    output logic             launch
);
    csr_t wv;
    assign wv     = csr_t'(wr_data);
    assign launch = wr_en && wv.txrdy && !csr.txrdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            csr    <= '0;
            toggle <= 1'b0;
        end else begin
            if (wr_en) begin
                csr.setup <= wv.setup;
                if (!wv.error)   csr.error   <= 1'b0;
                if (!wv.stalled) csr.stalled <= 1'b0;
                if (!wv.rxrdy)   csr.rxrdy   <= 1'b0;
                if (launch)      csr.txrdy   <= 1'b1;
            end
            // Hardware events take priority over software clears.
            if (evt.ack) csr.txrdy <= 1'b0;
            if (evt.stall) begin
                csr.stalled <= 1'b1;
                csr.txrdy   <= 1'b0;
            end
            if (evt.abort) begin
                csr.error <= 1'b1;
                csr.txrdy <= 1'b0;
            end
            if (rx_pkt) csr.rxrdy <= 1'b1;

            if (wr_en && wv.setup) toggle <= 1'b0;
            else if (evt.ack)      toggle <= !toggle;
        end
    end
endmodule

// File: rtl/ep0_irq_pulse.sv
module ep0_irq_pulse #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |src;
    end
endmodule

// File: rtl/ep0_host_csr.sv
module ep0_host_csr
    import ep0_pkg::*;
#(
    parameter int RETRY_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wr_data,
    output logic [CSR_W-1:0] csr_rd_data,
    input  logic             res_valid,
    input  logic [1:0]       res_kind,
    input  logic             rx_pkt,
    output logic             xact_start,
    output logic             xact_setup,
    output logic             xact_data1,
    output logic             ep0_irq
);
    localparam int N_IRQ = 4;

    csr_t            csr;
    seq_evt_t        evt;
    logic            launch;
    logic            toggle;
    logic [N_IRQ-1:0] irq_src;

    ep0_csr_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (csr_wr_en),
        .wr_data (csr_wr_data),
        .evt     (evt),
        .rx_pkt  (rx_pkt),
        .csr     (csr),
        .toggle  (toggle),
        .launch  (launch)
    );

    ep0_xact_seq #(.RETRY_LIMIT(RETRY_LIMIT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .res_valid (res_valid),
        .res_kind  (res_kind),
        .start     (xact_start),
        .evt       (evt)
    );

    assign irq_src = {rx_pkt, evt.abort, evt.stall, evt.ack};

    ep0_irq_pulse #(.N_SRC(N_IRQ)) u_irq (
        .clk (clk),
        .rst (rst),
        .src (irq_src),
        .irq (ep0_irq)
    );

    assign csr_rd_data = csr;
    assign xact_setup  = csr.setup;
    assign xact_data1  = toggle;
endmodule

// File: rtl/ep0_host_csr_chk.sv
module ep0_host_csr_chk (
    input logic       clk,
    input logic       rst,
    input logic       csr_wr_en,
    input logic [4:0] csr_wr_data,
    input logic [4:0] csr_rd_data,
    input logic       rx_pkt,
    input logic       xact_start,
    input logic       xact_setup,
    input logic       xact_data1,
    input logic       ep0_irq
);
    // R2
    start_token_chk: assert property (@(posedge clk) disable iff (rst)
        xact_start |-> (xact_setup == csr_rd_data[3]));

    // R11
    start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        xact_start |-> csr_rd_data[1]);

    // R3
    setup_data0_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && csr_wr_data[3]) |=> !xact_data1);

    // R4
    req_done_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(csr_rd_data[1]) |-> ep0_irq);

    // R6
    err_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(csr_rd_data[4]) |-> ep0_irq);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_rd_data[4] && !(csr_wr_en && !csr_wr_data[4])) |=> csr_rd_data[4]);

    // R9
    rx_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pkt |=> (csr_rd_data[0] && ep0_irq));
endmodule

bind ep0_host_csr ep0_host_csr_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .csr_wr_en   (csr_wr_en),
    .csr_wr_data (csr_wr_data),
    .csr_rd_data (csr_rd_data),
    .rx_pkt      (rx_pkt),
    .xact_start  (xact_start),
    .xact_setup  (xact_setup),
    .xact_data1  (xact_data1),
    .ep0_irq     (ep0_irq)
);

// File: tb/ep0_host_csr_tb_top.sv
module ep0_host_csr_tb_top;
    localparam logic [1:0] K_ACK = 2'd0, K_NAK = 2'd1, K_STL = 2'd2, K_NR = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csr_wr_en = 1'b0;
    logic [4:0] csr_wr_data = '0;
    logic [4:0] csr_rd_data;
    logic       res_valid;
    logic [1:0] res_kind;
    logic       rx_pkt = 1'b0;
    logic       xact_start, xact_setup, xact_data1, ep0_irq;

    typedef struct {
        bit setup;
        bit d1;
    } start_item_t;

    start_item_t exp_q[$];
    logic [1:0]  resp_q[$];
    int  checks = 0, fails = 0;
    int  irq_cnt = 0, exp_irq = 0, wide_irq = 0;
    bit  prev_irq = 1'b0;
    bit  exp_tog = 1'b0;
    bit  stray_req = 1'b0;

    always #5 clk = ~clk;

    ep0_host_csr dut_i (
        .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
        .csr_rd_data(csr_rd_data), .res_valid(res_valid), .res_kind(res_kind),
        .rx_pkt(rx_pkt), .xact_start(xact_start), .xact_setup(xact_setup),
        .xact_data1(xact_data1), .ep0_irq(ep0_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Packet engine stub and scoreboard monitor.
    initial begin
        res_valid = 1'b0;
        res_kind  = K_ACK;
        forever begin
            @(negedge clk);
            if (stray_req) begin
                res_valid = 1'b1;
                res_kind  = K_ACK;
                @(negedge clk);
                res_valid = 1'b0;
                stray_req = 1'b0;
            end
            while (xact_start) begin
                logic [1:0] k;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected start", 1, 0);
                    k = K_ACK;
                end else begin
                    start_item_t it;
                    it = exp_q.pop_front();
                    check(xact_setup == it.setup, "R2", "token", int'(xact_setup), int'(it.setup));
                    check(xact_data1 == it.d1, "R4", "toggle", int'(xact_data1), int'(it.d1));
                    k = (resp_q.size() != 0) ? resp_q.pop_front() : K_ACK;
                end
                @(negedge clk);
                res_valid = 1'b1;
                res_kind  = k;
                @(negedge clk);
                res_valid = 1'b0;
            end
        end
    end

    // Interrupt monitor (R10: pulses one cycle wide).
    initial forever begin
        @(negedge clk);
        if (ep0_irq) begin
            irq_cnt++;
            if (prev_irq) wide_irq++;
        end
        prev_irq = ep0_irq;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    task automatic csr_write(input logic [4:0] d);
        @(negedge clk);
        csr_wr_en   = 1'b1;
        csr_wr_data = d;
        @(negedge clk);
        csr_wr_en   = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while ((csr_rd_data[1] || exp_q.size() != 0) && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Push n expected attempts (result codes packed 2 bits each, first in bits 1:0).
    task automatic queue_attempts(input bit setup, input int n, input logic [11:0] ks);
        if (setup) exp_tog = 1'b0;
        for (int i = 0; i < n; i++) begin
            start_item_t it;
            it.setup = setup;
            it.d1    = exp_tog;
            exp_q.push_back(it);
            resp_q.push_back(ks[2*i +: 2]);
            if (ks[2*i +: 2] == K_ACK) exp_tog = ~exp_tog;
        end
        exp_irq++;
    endtask

    task automatic run_req(input bit setup, input int n, input logic [11:0] ks,
                           input logic [4:0] exp_rd, input string req);
        queue_attempts(setup, n, ks);
        csr_write({1'b0, setup, 1'b0, 1'b1, 1'b0});
        wait_done();
        check(csr_rd_data == exp_rd, req, "status word", int'(csr_rd_data), int'(exp_rd));
        check(irq_cnt == exp_irq, req, "irq count", irq_cnt, exp_irq);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(csr_rd_data == 5'd0, "R1", "reset word", int'(csr_rd_data), 0);
        check(!xact_start && !ep0_irq, "R1", "start/irq", int'({xact_start, ep0_irq}), 0);
        check(xact_data1 == 1'b0, "R1", "toggle", int'(xact_data1), 0);

        // R4: plain OUT requests, toggle flips each time
        run_req(1'b0, 1, {10'd0, K_ACK}, 5'b00000, "R4");
        run_req(1'b0, 1, {10'd0, K_ACK}, 5'b00000, "R4");
        run_req(1'b0, 1, {10'd0, K_ACK}, 5'b00000, "R4");
        // R2 R3: SETUP token with forced DATA0
        run_req(1'b1, 1, {10'd0, K_ACK}, 5'b01000, "R3");
        // R5: NAK retries with held toggle
        run_req(1'b0, 2, {8'd0, K_ACK, K_NAK}, 5'b00000, "R5");
        // R6: two silent attempts then ack, no error
        run_req(1'b0, 3, {6'd0, K_ACK, K_NR, K_NR}, 5'b00000, "R6");
        // R5: NAK resets the silent count
        run_req(1'b0, 6, {K_ACK, K_NR, K_NR, K_NAK, K_NR, K_NR}, 5'b00000, "R5");
        // R6: three silent attempts give error
        run_req(1'b0, 3, {6'd0, K_NR, K_NR, K_NR}, 5'b10000, "R6");
        // R11: no further attempts after the error
        repeat (12) @(negedge clk);
        check(csr_rd_data == 5'b10000, "R11", "idle after error", int'(csr_rd_data), 16);
        // R8: write 1 keeps, write 0 clears
        csr_write(5'b10000);
        @(negedge clk);
        check(csr_rd_data == 5'b10000, "R8", "error kept", int'(csr_rd_data), 16);
        csr_write(5'b00000);
        @(negedge clk);
        check(csr_rd_data == 5'b00000, "R8", "error cleared", int'(csr_rd_data), 0);
        // R7: STALL
        run_req(1'b0, 1, {10'd0, K_STL}, 5'b00100, "R7");
        csr_write(5'b00100);
        @(negedge clk);
        check(csr_rd_data == 5'b00100, "R8", "stall kept", int'(csr_rd_data), 4);
        csr_write(5'b00000);
        @(negedge clk);
        check(csr_rd_data == 5'b00000, "R8", "stall cleared", int'(csr_rd_data), 0);
        // R7: toggle held across the stall (checked by the scoreboard)
        run_req(1'b0, 1, {10'd0, K_ACK}, 5'b00000, "R7");
        // R9: receive packet
        @(negedge clk);
        rx_pkt = 1'b1;
        @(negedge clk);
        rx_pkt = 1'b0;
        exp_irq++;
        check(csr_rd_data == 5'b00001, "R9", "rx ready", int'(csr_rd_data), 1);
        @(negedge clk);
        check(irq_cnt == exp_irq, "R9", "irq count", irq_cnt, exp_irq);
        csr_write(5'b00000);
        @(negedge clk);
        check(csr_rd_data == 5'b00000, "R9", "rx cleared", int'(csr_rd_data), 0);
        // R12: second request write while pending starts nothing extra
        queue_attempts(1'b0, 3, {6'd0, K_ACK, K_NAK, K_NAK});
        csr_write(5'b00010);
        csr_write(5'b00010);
        wait_done();
        check(csr_rd_data == 5'b00000, "R12", "double request word", int'(csr_rd_data), 0);
        check(irq_cnt == exp_irq, "R12", "double request irq", irq_cnt, exp_irq);
        // R12: stray result while idle
        stray_req = 1'b1;
        wait (stray_req == 1'b0);
        repeat (3) @(negedge clk);
        check(csr_rd_data == 5'b00000, "R12", "stray result word", int'(csr_rd_data), 0);
        check(irq_cnt == exp_irq, "R12", "stray result irq", irq_cnt, exp_irq);
        run_req(1'b0, 1, {10'd0, K_ACK}, 5'b00000, "R12");
        // R10
        check(wide_irq == 0, "R10", "wide irq pulses", wide_irq, 0);
        check(exp_q.size() == 0, "R2", "unconsumed starts", exp_q.size(), 0);
        summary();
    end
endmodule